// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data enable, a pixel clock output and a frame start strobe, together with the current pixel and line position. It runs in the system clock domain and moves forward one pixel position on each cycle where the pixel clock enable from an upstream divider is high. The pixel fetch path uses the position outputs. The colour path uses the data enable.

Three packed words describe the raster: a horizontal timing word, a vertical timing word and a small control word. The block decodes their fields itself. The active width is coded in steps of 16 pixels. The horizontal sync and porch fields carry a minus-one bias. The vertical sync field and the line count carry a minus-one bias, while the vertical porches are stored as plain counts. Each line and each frame runs through sync, back porch, active and front porch, in that order. Every control output has its own inversion bit. Because no line pitch register exists, software sets the memory line pitch to the active width times the bytes per pixel.

Top module: `lcd_tg`

## Requirements
- R1: Horizontal word fields are: htim_i[7:2] = P, [15:8] = S, [23:16] = F, [31:24] = B. A line lasts (S+1) + (B+1) + 16*(P+1) + (F+1) pixel positions, in the order sync, back porch, active, front porch.
- R2: Vertical word fields are: vtim_i[9:0] = L, [15:10] = W, [23:16] = F, [31:24] = B. A frame lasts (W+1) + B + (L+1) + F lines, in the order sync, back porch, active, front porch. The porches carry no bias, so zero gives an empty region.
- R3: px_cnt_o gives the position within the line, from 0 up to the line length minus one, and then wraps to 0. hsync is asserted for positions below S+1.
- R4: ln_cnt_o gives the line within the frame and advances only when px_cnt_o wraps. vsync is asserted for whole lines below W+1.
- R5: Data enable is asserted only when both the pixel position and the line fall in their active regions.
- R6: ctrl_i[0] inverts hsync_o, ctrl_i[1] inverts vsync_o and ctrl_i[2] inverts de_o. At 0 each output is high when asserted.
- R7: pclk_o equals pix_en_i delayed by one clock, XOR ctrl_i[3]. Setting ctrl_i[3] moves the data change to the falling edge of the panel clock.
- R8: sof_o is high, with no inversion, exactly while the position is pixel 0 of line 0. This is the first pixel period of vsync.
- R9: The counters change only on a clock edge where pix_en_i is high. Otherwise they hold.
- R10: An active-low rst_ni clears both counters and the pixel clock register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel clock enable from the divider |
| htim_i | input | 30 | Horizontal timing word, bits 31:2 |
| vtim_i | input | 32 | Vertical timing word |
| ctrl_i | input | 4 | Inversion bits and pixel clock edge select |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Panel pixel clock |
| sof_o | output | 1 | Start-of-frame strobe |
| px_cnt_o | output | 12 | Pixel position in line |
| ln_cnt_o | output | 12 | Line position in frame |

## Verification
The bench uses the default 12-bit counter width. It programs small rasters of 16, 32 and 48 active pixels and one to three active lines, so each run covers several complete frames and frame wraps. One configuration pairs a one-pixel sync with zero vertical porches, which exercises the single-cycle and empty-region boundaries of both axes. Another drives the pixel enable on alternate cycles with every inversion bit set, which exercises the hold behaviour and all four polarity paths.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int TG_CNT_W = 12;

  // horizontal word field positions
  localparam int H_PPL_LSB = 2;
  localparam int H_PPL_W   = 6;
  localparam int H_SW_LSB  = 8;
  localparam int H_FP_LSB  = 16;
  localparam int H_BP_LSB  = 24;
  localparam int H_FLD_W   = 8;
  localparam int ACT_UNIT_SH = 4;  // active width in steps of 16

  // vertical word field positions
  localparam int V_LPP_LSB = 0;
  localparam int V_LPP_W   = 10;
  localparam int V_SW_LSB  = 10;
  localparam int V_SW_W    = 6;
  localparam int V_FP_LSB  = 16;
  localparam int V_BP_LSB  = 24;
  localparam int V_FLD_W   = 8;

  typedef struct packed {
    logic [TG_CNT_W-1:0] sync_len;
    logic [TG_CNT_W-1:0] back_len;
    logic [TG_CNT_W-1:0] act_len;
    logic [TG_CNT_W-1:0] front_len;
  } axis_len_t;
endpackage

// File: rtl/lcd_tg_decode.sv
module lcd_tg_decode
  import lcd_tg_pkg::*;
(
  input  logic [31:2] htim_i,
  input  logic [31:0] vtim_i,
  output axis_len_t   h_len_o,
  output axis_len_t   v_len_o
);
  localparam int W = TG_CNT_W;

  logic [H_PPL_W-1:0] ppl;
  assign ppl = htim_i[H_PPL_LSB +: H_PPL_W];

  always_comb begin
    h_len_o.sync_len  = W'(htim_i[H_SW_LSB +: H_FLD_W]) + W'(1);
    h_len_o.back_len  = W'(htim_i[H_BP_LSB +: H_FLD_W]) + W'(1);
    h_len_o.front_len = W'(htim_i[H_FP_LSB +: H_FLD_W]) + W'(1);
    h_len_o.act_len   = (W'(ppl) + W'(1)) << ACT_UNIT_SH;

    v_len_o.sync_len  = W'(vtim_i[V_SW_LSB +: V_SW_W]) + W'(1);
    v_len_o.act_len   = W'(vtim_i[V_LPP_LSB +: V_LPP_W]) + W'(1);
    v_len_o.back_len  = W'(vtim_i[V_BP_LSB +: V_FLD_W]);   // unbiased
    v_len_o.front_len = W'(vtim_i[V_FP_LSB +: V_FLD_W]);   // unbiased
  end
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W = TG_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  axis_len_t        len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             sync_o,
  output logic             act_o
);
  logic [CNT_W-1:0] cnt_q, act_start, act_end, total;

  assign act_start = len_i.sync_len + len_i.back_len;
  assign act_end   = act_start + len_i.act_len;
  assign total     = act_end + len_i.front_len;

  // >= keeps the counter bounded if the config shrinks mid-frame
  assign last_o = (cnt_q >= total - CNT_W'(1));
  assign sync_o = (cnt_q < len_i.sync_len);
  assign act_o  = (cnt_q >= act_start) && (cnt_q < act_end);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (adv_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/lcd_tg.sv
module lcd_tg
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W = TG_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic [31:2]      htim_i,
  input  logic [31:0]      vtim_i,
  input  logic [3:0]       ctrl_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             pclk_o,
  output logic             sof_o,
  output logic [CNT_W-1:0] px_cnt_o,
  output logic [CNT_W-1:0] ln_cnt_o
);
  localparam int INV_HS  = 0;
  localparam int INV_VS  = 1;
  localparam int INV_DE  = 2;
  localparam int PCLK_NE = 3;

  axis_len_t h_len, v_len;
  logic h_last, h_sync, h_act;
  logic v_last, v_sync, v_act;
  logic pclk_q;

  lcd_tg_decode u_dec (
    .htim_i (htim_i),
    .vtim_i (vtim_i),
    .h_len_o(h_len),
    .v_len_o(v_len)
  );

  lcd_tg_axis #(.CNT_W(CNT_W)) u_h (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (pix_en_i),
    .len_i (h_len),
    .cnt_o (px_cnt_o),
    .last_o(h_last),
    .sync_o(h_sync),
    .act_o (h_act)
  );

  lcd_tg_axis #(.CNT_W(CNT_W)) u_v (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (pix_en_i & h_last),
    .len_i (v_len),
    .cnt_o (ln_cnt_o),
    .last_o(v_last),
    .sync_o(v_sync),
    .act_o (v_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_q <= 1'b0;
    else         pclk_q <= pix_en_i;
  end

  logic unused_last;
  assign unused_last = v_last;

  assign hsync_o = h_sync ^ ctrl_i[INV_HS];
  assign vsync_o = v_sync ^ ctrl_i[INV_VS];
  assign de_o    = (h_act & v_act) ^ ctrl_i[INV_DE];
  assign pclk_o  = pclk_q ^ ctrl_i[PCLK_NE];
  assign sof_o   = (px_cnt_o == '0) && (ln_cnt_o == '0);
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_en_i,
  input logic [3:0]       ctrl_i,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input logic             pclk_o,
  input logic             sof_o,
  input logic [CNT_W-1:0] px_cnt_o,
  input logic [CNT_W-1:0] ln_cnt_o
);
  logic hs_act, vs_act, de_act;
  assign hs_act = hsync_o ^ ctrl_i[0];
  assign vs_act = vsync_o ^ ctrl_i[1];
  assign de_act = de_o ^ ctrl_i[2];

  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(px_cnt_o) && $stable(ln_cnt_o)); // R9

  AST_PX_STEP_OR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |=> (px_cnt_o == CNT_W'($past(px_cnt_o) + CNT_W'(1))) || (px_cnt_o == '0)); // R3

  AST_LN_ONLY_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |=> (px_cnt_o == '0) || (ln_cnt_o == $past(ln_cnt_o))); // R4

  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_act |-> !hs_act && !vs_act); // R5

  AST_SOF_IN_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> vs_act && hs_act); // R8

  AST_PCLK_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> pclk_o == ($past(pix_en_i) ^ ctrl_i[3])); // R7
endmodule

bind lcd_tg lcd_tg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pix_en_i(pix_en_i),
  .ctrl_i  (ctrl_i),
  .hsync_o (hsync_o),
  .vsync_o (vsync_o),
  .de_o    (de_o),
  .pclk_o  (pclk_o),
  .sof_o   (sof_o),
  .px_cnt_o(px_cnt_o),
  .ln_cnt_o(ln_cnt_o)
);

// File: tb/lcd_tg_tb_top.sv
`timescale 1ns/1ps
module lcd_tg_tb_top;
  localparam int CNT_W = 12;
  localparam int WD_CYCLES = 200000;

  typedef struct packed {
    logic [31:0] htim;
    logic [31:0] vtim;
    logic [3:0]  ctrl;
    logic        half_rate;
    logic [11:0] hsw, hbp, hact, hfp;
    logic [11:0] vsw, vbp, vact, vfp;
  } vec_t;

  // expected region lengths worked out by hand from R1/R2
  localparam vec_t VECS [3] = '{
    '{32'h0200_0100, 32'h0101_0002, 4'h0, 1'b0,
      12'd2, 12'd3, 12'd16, 12'd1, 12'd1, 12'd1, 12'd3, 12'd1},
    '{32'h0003_0004, 32'h0000_0801, 4'hF, 1'b1,
      12'd1, 12'd1, 12'd32, 12'd4, 12'd3, 12'd0, 12'd2, 12'd0},
    '{32'h0000_0008, 32'h0002_0000, 4'h2, 1'b0,
      12'd1, 12'd1, 12'd48, 12'd1, 12'd1, 12'd0, 12'd1, 12'd2}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_en = 1'b0;
  logic [31:0] htim = '0;
  logic [31:0] vtim = '0;
  logic [3:0]  ctrl = '0;
  logic hsync, vsync, de, pclk, sof;
  logic [CNT_W-1:0] px_cnt, ln_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lcd_tg dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .pix_en_i(pix_en),
    .htim_i  (htim[31:2]),
    .vtim_i  (vtim),
    .ctrl_i  (ctrl),
    .hsync_o (hsync),
    .vsync_o (vsync),
    .de_o    (de),
    .pclk_o  (pclk),
    .sof_o   (sof),
    .px_cnt_o(px_cnt),
    .ln_cnt_o(ln_cnt)
  );

  task automatic chk(input string req, input string nm, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, nm, got, exp, $time);
    end
  endtask

  task automatic check_all(input vec_t v, input int bh, input int bv, input logic prev_en);
    logic hs_e, vs_e, de_e;
    int hs0, vs0;
    hs0 = v.hsw + v.hbp;
    vs0 = v.vsw + v.vbp;
    hs_e = (bh < v.hsw);
    vs_e = (bv < v.vsw);
    de_e = (bh >= hs0) && (bh < hs0 + v.hact) && (bv >= vs0) && (bv < vs0 + v.vact);
    chk("R3", "px_cnt", px_cnt, bh);
    chk("R4", "ln_cnt", ln_cnt, bv);
    chk("R6_R3 hsync", "hsync", hsync, hs_e ^ v.ctrl[0]);
    chk("R6_R4 vsync", "vsync", vsync, vs_e ^ v.ctrl[1]);
    chk("R5_R6 de", "de", de, de_e ^ v.ctrl[2]);
    chk("R7", "pclk", pclk, prev_en ^ v.ctrl[3]);
    chk("R8", "sof", sof, (bh == 0 && bv == 0) ? 1 : 0);
  endtask

  initial begin
    #(WD_CYCLES * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // table walk: R1 R2 R9 over whole frames per configuration
    for (int k = 0; k < 3; k++) begin
      vec_t v;
      int htot, vtot, bh, bv, ncyc;
      logic prev_en;
      v = VECS[k];
      htot = v.hsw + v.hbp + v.hact + v.hfp;
      vtot = v.vsw + v.vbp + v.vact + v.vfp;
      @(negedge clk);
      rst_ni = 1'b0;
      pix_en = 1'b0;
      htim = v.htim;
      vtim = v.vtim;
      ctrl = v.ctrl;
      @(negedge clk);
      // R10 reset state
      chk("R10", "px_cnt rst", px_cnt, 0);
      chk("R10", "ln_cnt rst", ln_cnt, 0);
      chk("R10", "pclk rst", pclk, v.ctrl[3]);
      chk("R10_R8", "sof rst", sof, 1);
      rst_ni = 1'b1;
      bh = 0; bv = 0; prev_en = 1'b0;
      ncyc = htot * vtot * (v.half_rate ? 2 : 1) * 2 + 7;
      for (int c = 0; c < ncyc; c++) begin
        @(negedge clk);
        check_all(v, bh, bv, prev_en);  // R1 R2 via region lengths
        pix_en = v.half_rate ? ((c % 2) == 0) : 1'b1;
        @(posedge clk);
        prev_en = pix_en;
        if (pix_en) begin
          bh++;
          if (bh == htot) begin
            bh = 0;
            bv++;
            if (bv == vtot) bv = 0;
          end
        end
      end
    end

    // directed: R9 hold with enable low for a long stretch
    @(negedge clk);
    pix_en = 1'b0;
    begin
      int hx, lx;
      hx = px_cnt;
      lx = ln_cnt;
      repeat (5) @(negedge clk);
      chk("R9", "px hold", px_cnt, hx);
      chk("R9", "ln hold", ln_cnt, lx);
    end

    // directed: R10 asynchronous clear mid-frame
    pix_en = 1'b1;
    repeat (30) @(negedge clk);
    chk("R10", "px nonzero before rst", (px_cnt != 0) ? 1 : 0, 1);
    #3;
    rst_ni = 1'b0;
    #1;
    chk("R10", "px async clear", px_cnt, 0);
    chk("R10", "ln async clear", ln_cnt, 0);
    chk("R10", "pclk async clear", pclk, ctrl[3]);
    @(negedge clk);
    rst_ni = 1'b1;
    pix_en = 1'b0;
    @(negedge clk);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule